// File: doc/BRIEF.md
# Degree-3 Variable Node for Min-Sum LDPC Decoding

This block is the bit-side processing element of a (3,6)-regular LDPC decoder that runs the min-sum algorithm. Each instance owns one code bit. It takes the channel log-likelihood ratio of that bit and the three messages that the bit's three parity checks sent back. It returns three new messages, one per check, and an updated total LLR with its hard decision. The message to a given check adds the channel LLR to the messages of the two *other* checks only. The sender's own opinion is left out, so no check hears its own message echoed back.

All arithmetic is exact in a widened internal format. Every result is then clipped into the narrow message format of `W` bits, which is usually 2 or 4. The clip range is symmetric, so the most negative two's-complement code is never produced. A first-pass flag makes the node ignore the check inputs, which have no meaning before the first check update. In that pass every outgoing message is the clipped channel LLR. Results are registered and appear one clock after the inputs are presented with `in_valid`.

Top module: `vnode_deg3`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, every `ext_msg` lane, `total_llr` and `hard_bit` become 0 at that edge.
- R2: One cycle after a cycle with `in_valid` high, `ext_msg[i]` equals clip(`chan_llr` + sum of `chk_msg[j]` for j ≠ i). Every value is W-bit two's complement.
- R3: One cycle after a cycle with `in_valid` high, `total_llr` equals clip(`chan_llr` + `chk_msg[0]` + `chk_msg[1]` + `chk_msg[2]`).
- R4: `hard_bit` is 1 exactly when the unclipped full sum of R3 is negative, and 0 when that sum is zero or positive.
- R5: clip() maps any value above 2^(W-1)-1 to 2^(W-1)-1 and any value below -(2^(W-1)-1) to -(2^(W-1)-1). No output ever carries the code -2^(W-1). A channel LLR of -2^(W-1) alone is therefore output as -(2^(W-1)-1).
- R6: When `first_iter` is high with `in_valid`, all `chk_msg` inputs are treated as 0. Every `ext_msg` lane and `total_llr` then equal clip(`chan_llr`), whatever the check inputs hold.
- R7: `out_valid` is `in_valid` delayed by one cycle. After a cycle with `in_valid` low, all data outputs keep their previous values, whatever the data inputs hold.
- R8: Lane i of `ext_msg` belongs to the check that drives lane i of `chk_msg`. The only contribution that lane i leaves out is `chk_msg[i]`.
- R9: The node works at any W ≥ 2 with internal sums of W+2 bits, which hold four W-bit terms without wrapping. This applies at both W=2 and W=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are presented this cycle |
| first_iter | input | 1 | First pass: treat all check messages as zero |
| chan_llr | input | W | Channel LLR of the bit, two's complement |
| chk_msg | input | 3×W | Messages from the three connected checks, lane per check |
| out_valid | output | 1 | Outputs updated on the previous edge |
| ext_msg | output | 3×W | Extrinsic message toward each check, same lane order |
| total_llr | output | W | Clipped sum of channel LLR and all check messages |
| hard_bit | output | 1 | Hard decision, 1 when the full sum is negative |

## Verification
Clipping and the hard decision fall in the same cycle. A strongly negative total is clipped, yet its sign must still give `hard_bit` = 1. A sum of exactly zero must give 0. Vectors at the most negative and most positive input codes drive both at once. The first-pass mask and clipping also coincide: the most negative channel LLR is applied with `first_iter` set and with nonzero check inputs. All four outputs must then read -(2^(W-1)-1). Each output is compared with a reference sum-and-clip in the bench, at both widths.

// File: rtl/vnode_pkg.sv
package vnode_pkg;

    // number of checks attached to each bit in a (3,6)-regular code
    localparam int VN_DEG = 3;

    // extra integer bits so four W-bit terms add without wrap
    localparam int SUM_GUARD = 2;

    // where the check-side operands come from in a given pass
    typedef enum logic {
        MSG_LIVE = 1'b0,
        MSG_ZERO = 1'b1
    } msg_src_e;

    // largest magnitude kept by the symmetric clip
    function automatic int sat_limit(input int w);
        return (1 << (w - 1)) - 1;
    endfunction

endpackage

// File: rtl/vnode_msg_gate.sv
module vnode_msg_gate
    import vnode_pkg::*;
#(
    parameter int W  = 4,
    parameter int SW = W + SUM_GUARD
) (
    input  logic [VN_DEG-1:0][W-1:0] chk_msg,
    input  msg_src_e                 src,
    output logic signed [SW-1:0]     msg_x [VN_DEG]
);

    // sign-extend each lane, or force it to zero on the first pass
    for (genvar g = 0; g < VN_DEG; g++) begin : g_lane
        logic signed [SW-1:0] wide;
        assign wide     = {{(SW - W){chk_msg[g][W-1]}}, chk_msg[g]};
        assign msg_x[g] = (src == MSG_ZERO) ? '0 : wide;
    end

endmodule

// File: rtl/vnode_sum.sv
module vnode_sum
    import vnode_pkg::*;
#(
    parameter int W  = 4,
    parameter int SW = W + SUM_GUARD
) (
    input  logic [W-1:0]          llr,
    input  logic signed [SW-1:0]  msg_x [VN_DEG],
    output logic signed [SW-1:0]  total_x,
    output logic signed [SW-1:0]  ext_x [VN_DEG]
);

    logic signed [SW-1:0] llr_x;
    assign llr_x = {{(SW - W){llr[W-1]}}, llr};

    // full sum: channel plus every check
    always_comb begin
        total_x = llr_x;
        for (int k = 0; k < VN_DEG; k++) begin
            total_x = total_x + msg_x[k];
        end
    end

    // extrinsic lane: remove the receiving check's own term
    for (genvar g = 0; g < VN_DEG; g++) begin : g_ext
        assign ext_x[g] = total_x - msg_x[g];
    end

endmodule

// File: rtl/vnode_clip.sv
module vnode_clip
    import vnode_pkg::*;
#(
    parameter int W  = 4,
    parameter int SW = W + SUM_GUARD
) (
    input  logic signed [SW-1:0] din,
    output logic [W-1:0]         dout
);

    localparam int LIM = sat_limit(W);
    localparam logic signed [SW-1:0] HI = SW'(LIM);
    localparam logic signed [SW-1:0] LO = -HI;

    always_comb begin
        if (din > HI) begin
            dout = HI[W-1:0];
        end else if (din < LO) begin
            dout = LO[W-1:0];
        end else begin
            dout = din[W-1:0];
        end
    end

endmodule

// File: rtl/vnode_deg3.sv
module vnode_deg3
    import vnode_pkg::*;
#(
    parameter int W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     first_iter,
    input  logic [W-1:0]             chan_llr,
    input  logic [VN_DEG-1:0][W-1:0] chk_msg,
    output logic                     out_valid,
    output logic [VN_DEG-1:0][W-1:0] ext_msg,
    output logic [W-1:0]             total_llr,
    output logic                     hard_bit
);

    localparam int SW = W + SUM_GUARD;

    msg_src_e             src;
    logic signed [SW-1:0] msg_x   [VN_DEG];
    logic signed [SW-1:0] ext_x   [VN_DEG];
    logic signed [SW-1:0] total_x;
    logic [VN_DEG-1:0][W-1:0] ext_c;
    logic [W-1:0]             total_c;

    assign src = first_iter ? MSG_ZERO : MSG_LIVE;

    vnode_msg_gate #(.W(W), .SW(SW)) u_gate (
        .chk_msg (chk_msg),
        .src     (src),
        .msg_x   (msg_x)
    );

    vnode_sum #(.W(W), .SW(SW)) u_sum (
        .llr     (chan_llr),
        .msg_x   (msg_x),
        .total_x (total_x),
        .ext_x   (ext_x)
    );

    for (genvar g = 0; g < VN_DEG; g++) begin : g_clip
        vnode_clip #(.W(W), .SW(SW)) u_clip (
            .din  (ext_x[g]),
            .dout (ext_c[g])
        );
    end

    vnode_clip #(.W(W), .SW(SW)) u_clip_tot (
        .din  (total_x),
        .dout (total_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ext_msg   <= '0;
            total_llr <= '0;
            hard_bit  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                ext_msg   <= ext_c;
                total_llr <= total_c;
                hard_bit  <= total_x[SW-1];
            end
        end
    end

endmodule

// File: rtl/vnode_deg3_chk.sv
module vnode_deg3_chk
    import vnode_pkg::*;
#(
    parameter int W = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     first_iter,
    input logic                     out_valid,
    input logic [VN_DEG-1:0][W-1:0] ext_msg,
    input logic [W-1:0]             total_llr,
    input logic                     hard_bit
);

    localparam logic [W-1:0] MIN_CODE = {1'b1, {(W - 1){1'b0}}};

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && total_llr == '0 && ext_msg == '0 && !hard_bit)); // R1

    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R7

    AST_IDLE_NOVALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(ext_msg) && $stable(total_llr) && $stable(hard_bit))); // R7

    AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (total_llr != MIN_CODE && ext_msg[0] != MIN_CODE
                       && ext_msg[1] != MIN_CODE && ext_msg[2] != MIN_CODE)); // R5

    AST_HARD_SIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (hard_bit == total_llr[W-1])); // R4

    AST_FIRST_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && first_iter) |=> (ext_msg[0] == total_llr && ext_msg[1] == total_llr
                                      && ext_msg[2] == total_llr)); // R6

endmodule

bind vnode_deg3 vnode_deg3_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .first_iter (first_iter),
    .out_valid  (out_valid),
    .ext_msg    (ext_msg),
    .total_llr  (total_llr),
    .hard_bit   (hard_bit)
);

// File: tb/sim_vnode_deg3.sv
module sim_vnode_deg3;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // wide instance
    logic            v4 = 1'b0, f4 = 1'b0, ov4, hb4;
    logic [3:0]      l4 = '0, t4;
    logic [2:0][3:0] c4 = '0, e4;
    // narrow instance
    logic            v2 = 1'b0, f2 = 1'b0, ov2, hb2;
    logic [1:0]      l2 = '0, t2;
    logic [2:0][1:0] c2 = '0, e2;

    vnode_deg3 #(.W(4)) u0 (
        .clk(clk), .rst(rst), .in_valid(v4), .first_iter(f4),
        .chan_llr(l4), .chk_msg(c4), .out_valid(ov4),
        .ext_msg(e4), .total_llr(t4), .hard_bit(hb4)
    );

    vnode_deg3 #(.W(2)) u1 (
        .clk(clk), .rst(rst), .in_valid(v2), .first_iter(f2),
        .chan_llr(l2), .chk_msg(c2), .out_valid(ov2),
        .ext_msg(e2), .total_llr(t2), .hard_bit(hb2)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int clip(input int v, input int w);
        int lim = (1 << (w - 1)) - 1;
        if (v > lim)  return lim;
        if (v < -lim) return -lim;
        return v;
    endfunction

    function automatic int ext_of(input int w, input int i);
        if (w == 4) return int'($signed(e4[i]));
        return int'($signed(e2[i]));
    endfunction

    function automatic int tot_of(input int w);
        if (w == 4) return int'($signed(t4));
        return int'($signed(t2));
    endfunction

    // present one vector at the chosen width, then check one cycle later
    task automatic run(input int w, input int l, input int a, input int b, input int c,
                       input bit fi, input string tag);
        int m[3];
        int s;
        int msum;
        m[0] = a; m[1] = b; m[2] = c;
        msum = fi ? 0 : (a + b + c);
        s = l + msum;
        @(negedge clk);
        if (w == 4) begin
            v4 = 1'b1; f4 = fi; l4 = 4'(l);
            c4[0] = 4'(a); c4[1] = 4'(b); c4[2] = 4'(c);
        end else begin
            v2 = 1'b1; f2 = fi; l2 = 2'(l);
            c2[0] = 2'(a); c2[1] = 2'(b); c2[2] = 2'(c);
        end
        @(negedge clk);
        v4 = 1'b0; v2 = 1'b0;
        check("R7", {tag, " out_valid"}, (w == 4) ? int'(ov4) : int'(ov2), 1);
        for (int i = 0; i < 3; i++) begin
            check(fi ? "R6" : "R2/R8", {tag, " ext lane"}, ext_of(w, i),
                  clip(l + (fi ? 0 : (msum - m[i])), w));
        end
        check(fi ? "R6" : "R3/R5", {tag, " total"}, tot_of(w), clip(s, w));
        check("R4", {tag, " hard"}, (w == 4) ? int'(hb4) : int'(hb2), (s < 0) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int seed;
        int held[4];
        seed = 32'h5A17;
        void'($urandom(seed));
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "out_valid", int'(ov4), 0);
        check("R1", "total", int'(t4), 0);
        check("R1", "ext", int'(e4), 0);
        check("R1", "hard", int'(hb4), 0);
        check("R1", "narrow valid", int'(ov2), 0);
        rst = 1'b0;

        // directed, W=4
        run(4, 0, 0, 0, 0, 1'b0, "zero");
        run(4, 0, 1, 2, 4, 1'b0, "R8 lane order");
        run(4, 7, 7, 7, 7, 1'b0, "R5 max pos");
        run(4, -8, -8, -8, -8, 1'b0, "R5 max neg");
        run(4, 1, -1, -1, 0, 1'b0, "R4 small neg");
        run(4, 2, -1, -1, 0, 1'b0, "R4 zero sum");
        run(4, -8, 5, -3, 6, 1'b1, "R6 first min");
        run(4, 3, -8, -8, -8, 1'b1, "R6 first ignore");
        // directed, W=2 (R9)
        run(2, -2, -2, -2, -2, 1'b0, "R9 narrow neg");
        run(2, 1, 1, 1, 1, 1'b0, "R9 narrow pos");
        run(2, 1, -1, 0, 1, 1'b0, "R9 narrow mix");
        run(2, -2, 1, 1, 1, 1'b1, "R9 narrow first");

        // R7: idle cycle with changed data must not move outputs
        held[0] = ext_of(2, 0); held[1] = tot_of(2);
        run(4, 5, -2, 3, -6, 1'b0, "pre-hold");
        held[2] = ext_of(4, 1); held[3] = tot_of(4);
        @(negedge clk);
        l4 = 4'd3; c4 = '1; f4 = 1'b0;
        @(negedge clk);
        check("R7", "idle valid", int'(ov4), 0);
        check("R7", "idle ext", ext_of(4, 1), held[2]);
        check("R7", "idle total", tot_of(4), held[3]);
        check("R7", "other width ext", ext_of(2, 0), held[0]);
        check("R7", "other width total", tot_of(2), held[1]);

        // random vectors at both widths
        for (int k = 0; k < 300; k++) begin
            int w;
            int lo;
            int span;
            w = (k % 2 == 0) ? 4 : 2;
            lo = -(1 << (w - 1));
            span = 1 << w;
            run(w, lo + int'($urandom % span), lo + int'($urandom % span),
                lo + int'($urandom % span), lo + int'($urandom % span),
                ($urandom % 8) == 0, "rand R2");
        end

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "re-reset total", int'(t4), 0);
        check("R1", "re-reset ext", int'(e2), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule